// File: doc/BRIEF.md
# Power-Up and Restart Sequencer

This block decides when a digital power-supply controller may begin regulating. It holds in a reset phase until two supply qualifiers report good: one above the power-on-reset level and one above the undervoltage lockout level. It then counts a fixed core-settling interval and opens a configuration-load phase. In that phase it asks a separate memory-download engine to copy settings into the registers, using a one-cycle start pulse and a done input. A timeout ends the phase if the engine never answers.

After loading, a configuration bit picks the next step. Either soft start begins at once, or the block waits for an external power-on request. The only link to the soft-start ramp generator is a one-cycle start pulse. A supply or core overvoltage detection is handled through a 3-bit response field. The response can ignore the event, restart once the condition clears, restart through a fresh configuration load, or latch off until the supply is lost. The supply qualifiers, the overvoltage detection and the power-on request come from outside the clock domain, so each passes through a synchronizer first.

Top module: `pwr_seq_top`

## Requirements
- R1: Whenever either synchronized supply qualifier (`supply_ok`, `uvlo_ok`) is low, the next state is RESET (code 0), from any state. After reset the state is RESET and both pulses are low.
- R2: `supply_ok`, `uvlo_ok`, `ovp_det` and `pwr_on_req` pass through SYNC_STAGES (default 2) flops. From RESET, raising both qualifiers puts the state in CORE_SETTLE (code 1) SYNC_STAGES+1 clocks later.
- R3: CORE_SETTLE lasts exactly SETTLE_CYCLES clocks. The state then moves to DOWNLOAD (code 2).
- R4: `dl_start` is high for exactly one clock, in the first clock of each visit to DOWNLOAD. It is low at all other times.
- R5: `dl_done` high during DOWNLOAD ends the phase at the next clock edge. `dl_done` in any other state has no effect.
- R6: Without `dl_done`, DOWNLOAD ends after LOAD_CYCLES clocks.
- R7: When a load ends, `cfg_auto_start`=1 goes straight to SOFTSTART (code 4). Otherwise the state goes to WAIT_PSON (code 3) and stays there until the synchronized `pwr_on_req` is high. `ss_start` pulses for one clock in the first clock of each visit to SOFTSTART.
- R8: With `cfg_auto_start`=0, a low synchronized `pwr_on_req` in SOFTSTART returns the state to WAIT_PSON. With `cfg_auto_start`=1, `pwr_on_req` is ignored.
- R9: A synchronized overvoltage in CORE_SETTLE, DOWNLOAD, WAIT_PSON or SOFTSTART moves the state to FAULT (code 5) when `cfg_ov_resp[0]`=0. When `cfg_ov_resp[0]`=1 the overvoltage is ignored.
- R10: In FAULT with `cfg_ov_resp[2]`=1, the state stays in FAULT, even after the overvoltage clears, until a supply qualifier is lost.
- R11: In FAULT with `cfg_ov_resp[2]`=0, clearing of the overvoltage leads either to DOWNLOAD with a new `dl_start` pulse (`cfg_ov_resp[1]`=1) or to the after-load choice of R7 with no download (`cfg_ov_resp[1]`=0).
- R12: `dl_start` and `ss_start` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Supply above power-on-reset level (asynchronous) |
| uvlo_ok | input | 1 | Supply above undervoltage lockout level (asynchronous) |
| ovp_det | input | 1 | Supply or core rail above overvoltage threshold (asynchronous) |
| pwr_on_req | input | 1 | External power-on request (asynchronous) |
| cfg_auto_start | input | 1 | 1: start soft start right after loading |
| cfg_ov_resp | input | 3 | Overvoltage response: [0] ignore, [1] reload before restart, [2] latch off |
| dl_done | input | 1 | Download engine finished (synchronous) |
| dl_start | output | 1 | One-clock request to the download engine |
| ss_start | output | 1 | One-clock start for the soft-start ramp |
| seq_state | output | 3 | Current phase: 0 RESET, 1 CORE_SETTLE, 2 DOWNLOAD, 3 WAIT_PSON, 4 SOFTSTART, 5 FAULT |

## Verification
A wrong state register or a wrong transition shows on `seq_state` at the next clock. A wrong phase timer shows as a CORE_SETTLE or DOWNLOAD phase that is too long or too short by a whole number of clocks, and the `dl_start` or `ss_start` pulse moves with it. A synchronizer of the wrong depth moves every reaction to a qualifier, to an overvoltage or to the request by one clock per missing or extra stage. A wrong response decode shows within three clocks of an overvoltage change, as a missing or extra FAULT, download or restart. The bench therefore compares `seq_state` and both pulses against its own model on every clock, and it also times each phase in directed checks.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_RESET    = 3'd0,
    SEQ_SETTLE   = 3'd1,
    SEQ_LOAD     = 3'd2,
    SEQ_WAIT_REQ = 3'd3,
    SEQ_RUN      = 3'd4,
    SEQ_FAULT    = 3'd5
  } seq_state_e;

  // bit positions inside the overvoltage response field
  localparam int OVR_IGNORE = 0;
  localparam int OVR_RELOAD = 1;
  localparam int OVR_LATCH  = 2;
  localparam int OVR_W      = 3;

  // index of each asynchronous input inside the synchronizer bundle
  localparam int IN_SUPPLY = 0;
  localparam int IN_UVLO   = 1;
  localparam int IN_OV     = 2;
  localparam int IN_REQ    = 3;
  localparam int IN_W      = 4;

  // the phase that follows a finished configuration load
  function automatic seq_state_e post_load(input logic auto_start);
    return auto_start ? SEQ_RUN : SEQ_WAIT_REQ;
  endfunction

endpackage

// File: rtl/pwr_seq_rst_sync.sv
`timescale 1ns/1ps
module pwr_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ni = stage_q[1];
endmodule

// File: rtl/pwr_seq_sync.sv
`timescale 1ns/1ps
module pwr_seq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign d_sync = d_async;
    end else begin : g_chain
      logic [WIDTH-1:0] q [STAGES];

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q[0] <= '0;
        else         q[0] <= d_async;
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) q[i] <= '0;
          else         q[i] <= q[i-1];
        end
      end

      assign d_sync = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer #(
  parameter int SETTLE_CYCLES = 4000,
  parameter int LOAD_CYCLES   = 5000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clear,
  input  logic run,
  output logic settle_done,
  output logic load_expired
);
  localparam int MAX_CYC = (SETTLE_CYCLES > LOAD_CYCLES) ? SETTLE_CYCLES : LOAD_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] LOAD_LAST   = CW'(LOAD_CYCLES - 1);
  localparam logic [CW-1:0] CNT_MAX     = CW'(MAX_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign cnt_en = clear | (run & ~at_max);
  assign cnt_d  = clear ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settle_done  = (cnt_q == SETTLE_LAST);
  assign load_expired = (cnt_q == LOAD_LAST);
endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rail_ok,
  input  logic             ov_s,
  input  logic             req_s,
  input  logic             dl_done,
  input  logic             cfg_auto_start,
  input  logic [OVR_W-1:0] cfg_ov_resp,
  input  logic             settle_done,
  input  logic             load_expired,
  output seq_state_e       state_q,
  output logic             state_chg,
  output logic             timed,
  output logic             dl_start,
  output logic             ss_start
);
  seq_state_e state_d;
  logic       ov_act, dl_start_d, ss_start_d;

  assign ov_act = ov_s & ~cfg_ov_resp[OVR_IGNORE] &
                  (state_q != SEQ_RESET) & (state_q != SEQ_FAULT);

  always_comb begin
    state_d = state_q;
    if (!rail_ok) begin
      state_d = SEQ_RESET;
    end else if (ov_act) begin
      state_d = SEQ_FAULT;
    end else begin
      unique case (state_q)
        SEQ_RESET:    state_d = SEQ_SETTLE;
        SEQ_SETTLE:   if (settle_done) state_d = SEQ_LOAD;
        SEQ_LOAD:     if (dl_done || load_expired) state_d = post_load(cfg_auto_start);
        SEQ_WAIT_REQ: if (cfg_auto_start || req_s) state_d = SEQ_RUN;
        SEQ_RUN:      if (!cfg_auto_start && !req_s) state_d = SEQ_WAIT_REQ;
        SEQ_FAULT: begin
          if (!cfg_ov_resp[OVR_LATCH] && !ov_s)
            state_d = cfg_ov_resp[OVR_RELOAD] ? SEQ_LOAD : post_load(cfg_auto_start);
        end
        default:      state_d = SEQ_RESET;
      endcase
    end
  end

  assign state_chg  = (state_d != state_q);
  assign timed      = (state_q == SEQ_SETTLE) | (state_q == SEQ_LOAD);
  assign dl_start_d = (state_d == SEQ_LOAD) & (state_q != SEQ_LOAD);
  assign ss_start_d = (state_d == SEQ_RUN)  & (state_q != SEQ_RUN);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_RESET;
      dl_start <= 1'b0;
      ss_start <= 1'b0;
    end else begin
      state_q  <= state_d;
      dl_start <= dl_start_d;
      ss_start <= ss_start_d;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4000,
  parameter int LOAD_CYCLES   = 5000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       uvlo_ok,
  input  logic       ovp_det,
  input  logic       pwr_on_req,
  input  logic       cfg_auto_start,
  input  logic [2:0] cfg_ov_resp,
  input  logic       dl_done,
  output logic       dl_start,
  output logic       ss_start,
  output logic [2:0] seq_state
);
  logic            rst_ni;
  logic [IN_W-1:0] raw_in, syn_in;
  logic            rail_ok, ov_s, req_s;
  logic            settle_done, load_expired, state_chg, timed;
  seq_state_e      state_q;

  pwr_seq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  always_comb begin
    raw_in            = '0;
    raw_in[IN_SUPPLY] = supply_ok;
    raw_in[IN_UVLO]   = uvlo_ok;
    raw_in[IN_OV]     = ovp_det;
    raw_in[IN_REQ]    = pwr_on_req;
  end

  pwr_seq_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .d_async (raw_in),
    .d_sync  (syn_in)
  );

  assign rail_ok = syn_in[IN_SUPPLY] & syn_in[IN_UVLO];
  assign ov_s    = syn_in[IN_OV];
  assign req_s   = syn_in[IN_REQ];

  pwr_seq_timer #(.SETTLE_CYCLES(SETTLE_CYCLES), .LOAD_CYCLES(LOAD_CYCLES)) u_timer (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .clear        (state_chg),
    .run          (timed),
    .settle_done  (settle_done),
    .load_expired (load_expired)
  );

  pwr_seq_fsm u_fsm (
    .clk            (clk),
    .rst_ni         (rst_ni),
    .rail_ok        (rail_ok),
    .ov_s           (ov_s),
    .req_s          (req_s),
    .dl_done        (dl_done),
    .cfg_auto_start (cfg_auto_start),
    .cfg_ov_resp    (cfg_ov_resp),
    .settle_done    (settle_done),
    .load_expired   (load_expired),
    .state_q        (state_q),
    .state_chg      (state_chg),
    .timed          (timed),
    .dl_start       (dl_start),
    .ss_start       (ss_start)
  );

  assign seq_state = state_q;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4000,
  parameter int LOAD_CYCLES   = 5000
) (
  input logic       clk,
  input logic       rst_ni,
  input logic       rail_ok,
  input logic       ov_s,
  input logic [2:0] cfg_ov_resp,
  input logic [2:0] state,
  input logic       dl_start,
  input logic       ss_start
);
  logic [31:0] settle_cnt, load_cnt;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_cnt <= '0;
      load_cnt   <= '0;
    end else begin
      settle_cnt <= (state == SEQ_SETTLE) ? settle_cnt + 32'd1 : 32'd0;
      load_cnt   <= (state == SEQ_LOAD)   ? load_cnt + 32'd1   : 32'd0;
    end
  end

  a_r1_rail_loss: assert property (@(posedge clk) disable iff (!rst_ni)
    !rail_ok |=> state == SEQ_RESET);

  a_r3_settle_len: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == SEQ_LOAD && $past(state) == SEQ_SETTLE) |-> $past(settle_cnt) == 32'(SETTLE_CYCLES - 1));

  a_r4_load_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    dl_start |-> (state == SEQ_LOAD && $past(state) != SEQ_LOAD));

  a_r6_load_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    state == SEQ_LOAD |-> load_cnt <= 32'(LOAD_CYCLES - 1));

  a_r7_run_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    ss_start |-> (state == SEQ_RUN && $past(state) != SEQ_RUN));

  a_r9_ov_fault: assert property (@(posedge clk) disable iff (!rst_ni)
    (rail_ok && ov_s && !cfg_ov_resp[OVR_IGNORE] && state != SEQ_RESET && state != SEQ_FAULT)
      |=> state == SEQ_FAULT);

  a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == SEQ_FAULT && cfg_ov_resp[OVR_LATCH] && rail_ok) |=> state == SEQ_FAULT);

  a_r12_pulse_excl: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({dl_start, ss_start}));
endmodule

bind pwr_seq_top pwr_seq_chk #(
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .LOAD_CYCLES   (LOAD_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .rail_ok     (rail_ok),
  .ov_s        (ov_s),
  .cfg_ov_resp (cfg_ov_resp),
  .state       (seq_state),
  .dl_start    (dl_start),
  .ss_start    (ss_start)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;
  localparam int S = 20;
  localparam int L = 30;
  localparam int Y = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0, uvlo_ok = 1'b0, ovp_det = 1'b0, pwr_on_req = 1'b0;
  logic       cfg_auto_start = 1'b0, dl_done = 1'b0;
  logic [2:0] cfg_ov_resp = 3'b000;
  logic       dl_start, ss_start;
  logic [2:0] seq_state;

  pwr_seq_top #(.SETTLE_CYCLES(S), .LOAD_CYCLES(L), .SYNC_STAGES(Y)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uvlo_ok(uvlo_ok),
    .ovp_det(ovp_det), .pwr_on_req(pwr_on_req), .cfg_auto_start(cfg_auto_start),
    .cfg_ov_resp(cfg_ov_resp), .dl_done(dl_done), .dl_start(dl_start),
    .ss_start(ss_start), .seq_state(seq_state)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference model, updated on every rising edge
  int       m_st = 0, m_cnt = 0, rc = 0;
  bit       m_dl = 0, m_ss = 0, started = 0;
  bit [3:0] hq[$];

  always @(posedge clk) begin : model
    bit [3:0] cur;
    bit good, ovs, reqs;
    int nst;
    started = 1;
    if (!rst_n) rc = 0; else if (rc < 10) rc++;
    if (rc <= 2) begin
      m_st = 0; m_cnt = 0; m_dl = 0; m_ss = 0;
      hq.delete();
      for (int i = 0; i < Y; i++) hq.push_back(4'b0);
    end else begin
      cur  = hq.pop_front();
      hq.push_back({pwr_on_req, ovp_det, uvlo_ok, supply_ok});
      good = cur[0] && cur[1];
      ovs  = cur[2];
      reqs = cur[3];
      nst  = m_st;
      if (!good) nst = 0;
      else if (ovs && !cfg_ov_resp[0] && m_st != 0 && m_st != 5) nst = 5;
      else begin
        case (m_st)
          0: nst = 1;
          1: if (m_cnt == S - 1) nst = 2;
          2: if (dl_done || m_cnt == L - 1) nst = cfg_auto_start ? 4 : 3;
          3: if (cfg_auto_start || reqs) nst = 4;
          4: if (!cfg_auto_start && !reqs) nst = 3;
          5: if (!cfg_ov_resp[2] && !ovs) nst = cfg_ov_resp[1] ? 2 : (cfg_auto_start ? 4 : 3);
          default: nst = 0;
        endcase
      end
      m_dl  = (nst == 2) && (m_st != 2);
      m_ss  = (nst == 4) && (m_st != 4);
      m_cnt = (nst != m_st) ? 0 : m_cnt + 1;
      m_st  = nst;
    end
  end

  int dl_seen = 0, both_seen = 0;
  always @(negedge clk) begin
    if (started) begin
      chk(seq_state === 3'(m_st) && dl_start === m_dl && ss_start === m_ss, tag,
          "model state/pulses", {29'd0, seq_state}, m_st);
      if (dl_start === 1'b1) dl_seen++;
      if (dl_start === 1'b1 && ss_start === 1'b1) both_seen++;
    end
  end

  task automatic wait_st(input int code, input int max, output int n);
    n = 0;
    while (seq_state !== 3'(code) && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin : stim
    int n, m, d0;
    ticks(4);
    rst_n = 1'b1;
    ticks(4);
    tag = "R1";
    chk(seq_state == 3'd0 && !dl_start && !ss_start, "R1", "reset state", seq_state, 0);

    // R2: qualifier latency
    tag = "R2";
    supply_ok = 1'b1; uvlo_ok = 1'b1;
    n = 0;
    while (seq_state != 3'd1 && n < 20) begin @(negedge clk); n++; end
    chk(n == Y + 1, "R2", "qualifier to settle latency", n, Y + 1);

    // R3: settle length, R4: download pulse
    tag = "R3";
    m = 0;
    while (seq_state == 3'd1 && m < 100) begin @(negedge clk); m++; end
    chk(m == S, "R3", "settle cycles", m, S);
    tag = "R4";
    chk(seq_state == 3'd2 && dl_start, "R4", "dl_start on first load clock", dl_start, 1);
    ticks(1);
    chk(!dl_start, "R4", "dl_start one clock wide", dl_start, 0);

    // R5: done ends load; R7: waits for request
    tag = "R5";
    ticks(2);
    dl_done = 1'b1; ticks(1); dl_done = 1'b0;
    chk(seq_state == 3'd3, "R5", "done ends load", seq_state, 3);
    tag = "R7";
    ticks(10);
    chk(seq_state == 3'd3, "R7", "waits for request", seq_state, 3);
    pwr_on_req = 1'b1;
    wait_st(4, 10, n);
    chk(n == Y + 1 && ss_start, "R7", "request starts soft start", n, Y + 1);

    // R8: request loss
    tag = "R8";
    pwr_on_req = 1'b0;
    wait_st(3, 10, n);
    chk(seq_state == 3'd3, "R8", "request loss returns to wait", seq_state, 3);
    pwr_on_req = 1'b1;
    wait_st(4, 10, n);

    // R5: done outside download ignored
    tag = "R5";
    d0 = dl_seen;
    dl_done = 1'b1; ticks(1); dl_done = 1'b0; ticks(2);
    chk(seq_state == 3'd4 && dl_seen == d0, "R5", "done ignored while running", seq_state, 4);

    // R9: ignore, then fault
    tag = "R9";
    cfg_ov_resp = 3'b001; ovp_det = 1'b1; ticks(8);
    chk(seq_state == 3'd4, "R9", "ignored overvoltage", seq_state, 4);
    cfg_ov_resp = 3'b000;
    wait_st(5, 10, n);
    chk(seq_state == 3'd5, "R9", "overvoltage fault", seq_state, 5);

    // R11: restart without reload
    tag = "R11";
    d0 = dl_seen;
    ovp_det = 1'b0;
    wait_st(4, 20, n);
    chk(seq_state == 3'd4 && dl_seen == d0, "R11", "restart without download", dl_seen - d0, 0);

    // R11 with reload, R6 timeout
    cfg_ov_resp = 3'b010; ovp_det = 1'b1;
    wait_st(5, 10, n);
    ovp_det = 1'b0;
    wait_st(2, 10, n);
    chk(seq_state == 3'd2 && dl_start, "R11", "reload after fault", dl_start, 1);
    tag = "R6";
    m = 0;
    while (seq_state == 3'd2 && m < 200) begin @(negedge clk); m++; end
    chk(m == L, "R6", "download timeout cycles", m, L);
    wait_st(4, 10, n);

    // R10: latch off until rail loss
    tag = "R10";
    cfg_ov_resp = 3'b100; ovp_det = 1'b1;
    wait_st(5, 10, n);
    ovp_det = 1'b0; ticks(20);
    chk(seq_state == 3'd5, "R10", "latched fault holds", seq_state, 5);
    tag = "R1";
    uvlo_ok = 1'b0;
    wait_st(0, 10, n);
    chk(n == Y + 1, "R1", "lockout loss to reset latency", n, Y + 1);
    cfg_ov_resp = 3'b000;

    // R7 auto start, R8 request ignored
    tag = "R7";
    cfg_auto_start = 1'b1; pwr_on_req = 1'b0; uvlo_ok = 1'b1;
    wait_st(2, 100, n);
    ticks(1);
    dl_done = 1'b1; ticks(1); dl_done = 1'b0;
    chk(seq_state == 3'd4 && ss_start, "R7", "auto start after load", seq_state, 4);
    tag = "R8";
    ticks(10);
    chk(seq_state == 3'd4, "R8", "request ignored in auto mode", seq_state, 4);

    // R1: supply loss during download
    tag = "R1";
    uvlo_ok = 1'b0; wait_st(0, 10, n);
    uvlo_ok = 1'b1; wait_st(2, 100, n);
    supply_ok = 1'b0;
    wait_st(0, 10, n);
    chk(n == Y + 1, "R1", "supply loss during download", n, Y + 1);
    ticks(5);

    tag = "R12";
    chk(both_seen == 0, "R12", "pulses exclusive", both_seen, 0);
    finish_run();
  end
endmodule